// File: doc/BRIEF.md
# Byte-wide one-time-programmable memory with control-pin mode decoder

This block is a synthesizable, clocked stand-in for a byte-wide one-time-programmable memory. It takes the active-low chip enable, output enable and program strobe, an address bus, and an 8-bit data bus with separate in and out ports plus an output-enable. Two digital flags replace the analog supply levels. `progSupply` says that the programming supply is raised. `idVoltage` says that the high identification level is present on address line 9. Each cycle the control pins are decoded into one mode: read, output disable, standby, program, program verify, program inhibit or product identification.

The array powers up with every bit at 1. A program operation can only clear bits. It stores the bitwise AND of the old byte and the data bus, and it acts once, on the clock edge that first sees the program strobe low. In product identification, fixed identifier bytes with odd parity are returned instead of array contents. The output bus and its enable are combinational from the current pins and the stored array. Writes take effect on the rising clock edge.

Top module: `otp_mode_array`

## Requirements
- R1: After reset every byte of the array reads 0xFF.
- R2: With `progSupply`=1, `chipEnN`=0 and `outEnN`=1, the first clock edge that samples `progStrobeN` low after it was sampled high stores (old byte AND `dataIn`) at `addr`. Further edges with the strobe held low write nothing, even if `dataIn` changes.
- R3: Programming never sets a bit. Writing 0xFF leaves the byte unchanged.
- R4: Program verify (`progSupply`=1, `chipEnN`=0, `outEnN`=0, `progStrobeN`=1) drives the addressed array byte, with `dataOe`=1.
- R5: Program inhibit (`chipEnN`=1, `progSupply`=1) writes nothing on any strobe activity and holds `dataOe`=0.
- R6: Output disable (`chipEnN`=0, `outEnN`=1, and not in program mode) holds `dataOe`=0.
- R7: Read (`progSupply`=0, `chipEnN`=0, `outEnN`=0, `idVoltage`=0) drives the addressed array byte, with `dataOe`=1.
- R8: Identification (read conditions with `idVoltage`=1) with `addr[1]`=1 returns 0x1C when `addr[0]`=0 and 0x02 when `addr[0]`=1. `idVoltage` has no effect while `progSupply`=1.
- R9: Identification with `addr[1]`=0 returns 0x7F for either value of `addr[0]`.
- R10: Every identifier byte driven has an odd number of ones across all 8 bits.
- R11: Standby (`chipEnN`=1, `progSupply`=0) holds `dataOe`=0.
- R12: With `progSupply`=1, `chipEnN`=0 and both `outEnN` and `progStrobeN` low, the block neither drives nor writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; sets every cell to 1 |
| chipEnN | input | 1 | Active-low chip enable |
| outEnN | input | 1 | Active-low output enable |
| progStrobeN | input | 1 | Active-low program strobe |
| progSupply | input | 1 | Programming supply raised |
| idVoltage | input | 1 | Identification level on address line 9 |
| addr | input | ADDR_W | Byte address |
| dataIn | input | 8 | Data to program |
| dataOut | output | 8 | Data driven out |
| dataOe | output | 1 | Output bus drive enable |

## Verification
The bench builds the block with `ADDR_W`=4, a 16-byte array. At that size the random phase returns to each cell many times, so repeated AND-writes drive bytes all the way down to zero. This exercises the bit-clearing rule across the full byte range. The small depth also puts the identification address bits and the array addresses on the same few lines, so switching between identification and array reads happens often at identical addresses.

// File: rtl/otp_pkg.sv
package otp_pkg;

  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_INHIBIT,
    MODE_OUTOFF,
    MODE_READ,
    MODE_IDENT,
    MODE_PROGRAM,
    MODE_VERIFY,
    MODE_CONFLICT
  } otpMode_e;

  typedef struct packed {
    logic driveOut;
    logic selId;
    logic writeEn;
  } otpStrobe_t;

  localparam logic [7:0] ID_MAKER  = 8'h1C;
  localparam logic [7:0] ID_PART   = 8'h02;
  localparam logic [7:0] ID_CONT   = 8'h7F;

endpackage

// File: rtl/otp_ctrl.sv
module otp_ctrl
  import otp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       chipEnN,
  input  logic       outEnN,
  input  logic       progStrobeN,
  input  logic       progSupply,
  input  logic       idVoltage,
  output otpMode_e   mode,
  output otpStrobe_t strobes
);

  logic strobeWasHigh;

  always_comb begin
    if (chipEnN) begin
      mode = progSupply ? MODE_INHIBIT : MODE_STANDBY;
    end else if (progSupply) begin
      unique case ({outEnN, progStrobeN})
        2'b10:   mode = MODE_PROGRAM;
        2'b01:   mode = MODE_VERIFY;
        2'b11:   mode = MODE_OUTOFF;
        default: mode = MODE_CONFLICT;
      endcase
    end else if (outEnN) begin
      mode = MODE_OUTOFF;
    end else begin
      mode = idVoltage ? MODE_IDENT : MODE_READ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobeWasHigh <= 1'b1;
    else       strobeWasHigh <= progStrobeN;
  end

  always_comb begin
    strobes.driveOut = (mode == MODE_READ) || (mode == MODE_VERIFY) ||
                       (mode == MODE_IDENT);
    strobes.selId    = (mode == MODE_IDENT);
    strobes.writeEn  = (mode == MODE_PROGRAM) && strobeWasHigh;
  end

endmodule

// File: rtl/otp_datapath.sv
module otp_datapath
  import otp_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  otpStrobe_t        strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              dataOe
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];
  logic [7:0] arrayByte;
  logic [7:0] idByte;

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        cells[w] <= 8'hFF;
      else if (strobes.writeEn && (addr == ADDR_W'(w)))
        cells[w] <= cells[w] & dataIn;
    end
  end

  assign arrayByte = cells[addr];

  always_comb begin
    if (!addr[1])     idByte = ID_CONT;
    else if (addr[0]) idByte = ID_PART;
    else              idByte = ID_MAKER;
  end

  always_comb begin
    dataOe  = strobes.driveOut;
    if (!strobes.driveOut) dataOut = 8'h00;
    else if (strobes.selId) dataOut = idByte;
    else dataOut = arrayByte;
  end

endmodule

// File: rtl/otp_mode_array.sv
module otp_mode_array
  import otp_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEnN,
  input  logic              outEnN,
  input  logic              progStrobeN,
  input  logic              progSupply,
  input  logic              idVoltage,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              dataOe
);

  otpMode_e   mode;
  otpStrobe_t strobes;

  otp_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .chipEnN     (chipEnN),
    .outEnN      (outEnN),
    .progStrobeN (progStrobeN),
    .progSupply  (progSupply),
    .idVoltage   (idVoltage),
    .mode        (mode),
    .strobes     (strobes)
  );

  otp_datapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .addr    (addr),
    .dataIn  (dataIn),
    .dataOut (dataOut),
    .dataOe  (dataOe)
  );

endmodule

// File: rtl/otp_mode_array_chk.sv
module otp_mode_array_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              chipEnN,
  input logic              outEnN,
  input logic              progStrobeN,
  input logic              progSupply,
  input logic              idVoltage,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        dataOut,
  input logic              dataOe
);

  logic              arrayView;
  logic              prevArray;
  logic [ADDR_W-1:0] prevAddr;
  logic [7:0]        prevOut;

  assign arrayView = dataOe && !(idVoltage && !progSupply);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevArray <= 1'b0;
      prevAddr  <= '0;
      prevOut   <= 8'h00;
    end else begin
      prevArray <= arrayView;
      prevAddr  <= addr;
      prevOut   <= dataOut;
    end
  end

  // R11 R5
  ce_high_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    chipEnN |-> !dataOe);

  // R6
  out_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!chipEnN && outEnN && !(progSupply && !progStrobeN)) |-> !dataOe);

  // R7
  read_drives_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!chipEnN && !outEnN && !progSupply) |-> dataOe);

  // R10
  id_parity_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && idVoltage && !progSupply) |-> ($countones(dataOut) % 2 == 1));

  // R3
  bits_only_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (arrayView && prevArray && addr == prevAddr) |-> ((dataOut & ~prevOut) == 8'h00));

  // R12
  conflict_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!chipEnN && progSupply && !outEnN && !progStrobeN) |-> !dataOe);

endmodule

bind otp_mode_array otp_mode_array_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .chipEnN     (chipEnN),
  .outEnN      (outEnN),
  .progStrobeN (progStrobeN),
  .progSupply  (progSupply),
  .idVoltage   (idVoltage),
  .addr        (addr),
  .dataOut     (dataOut),
  .dataOe      (dataOe)
);

// File: tb/otp_mode_array_tb.sv
module otp_mode_array_tb_top;

  localparam int AW = 4;
  localparam int NB = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          chipEnN = 1'b1, outEnN = 1'b1, progStrobeN = 1'b1;
  logic          progSupply = 1'b0, idVoltage = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    dataIn = 8'h00;
  logic [7:0]    dataOut;
  logic          dataOe;

  int vectors = 0;
  int fails   = 0;
  int mem [NB];
  int prevHigh = 1;
  bit done = 0;

  always #2 clk = ~clk;

  otp_mode_array #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .outEnN(outEnN),
    .progStrobeN(progStrobeN), .progSupply(progSupply), .idVoltage(idVoltage),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe)
  );

  function automatic string reqOf();
    if (chipEnN) return progSupply ? "R5" : "R11";
    if (progSupply) begin
      if (outEnN && !progStrobeN) return "R2";
      if (!outEnN && progStrobeN) return "R4";
      if (!outEnN && !progStrobeN) return "R12";
      return "R6";
    end
    if (outEnN) return "R6";
    if (idVoltage) return addr[1] ? "R8" : "R9";
    return "R7";
  endfunction

  task automatic step(input logic ce, input logic oe, input logic pg,
                      input logic vs, input logic idv, input int a, input int d);
    int expOe;
    int expVal;
    @(negedge clk);
    chipEnN = ce; outEnN = oe; progStrobeN = pg; progSupply = vs;
    idVoltage = idv; addr = AW'(a); dataIn = 8'(d);
    #1;
    expOe = 0; expVal = 0;
    if (!ce && !oe && !vs) begin
      expOe = 1;
      if (idv) expVal = (a & 2) ? ((a & 1) ? 'h02 : 'h1C) : 'h7F;
      else expVal = mem[a];
    end else if (!ce && !oe && vs && pg) begin
      expOe = 1; expVal = mem[a];
    end
    vectors++;
    if (dataOe !== 1'(expOe) || (expOe == 1 && dataOut !== 8'(expVal))) begin
      fails++;
      $display("FAIL %s: oe=%0b out=%02h expected oe=%0b out=%02h",
               reqOf(), dataOe, dataOut, expOe, expVal);
    end
    if (expOe == 1 && !vs && idv) begin
      vectors++;
      if ($countones(dataOut) % 2 != 1) begin
        fails++;
        $display("FAIL R10: id byte %02h has even parity, expected odd", dataOut);
      end
    end
    @(posedge clk);
    if (!ce && vs && oe && !pg && prevHigh == 1) mem[a] = mem[a] & d;
    prevHigh = pg;
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NB; i++) mem[i] = 'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1 R7: fresh array reads all ones
    for (int i = 0; i < NB; i++) step(0, 0, 1, 0, 0, i, 0);
    // R11 standby, R6 output disable
    step(1, 0, 0, 0, 0, 3, 0);
    step(0, 1, 1, 0, 0, 3, 0);
    // R2: single write on strobe fall, held low with new data
    step(0, 1, 1, 1, 0, 5, 'hA5);
    step(0, 1, 0, 1, 0, 5, 'hA5);
    step(0, 1, 0, 1, 0, 5, 'h0F);
    step(0, 1, 1, 1, 0, 5, 'h0F);
    // R4 verify, R7 read
    step(0, 0, 1, 1, 0, 5, 0);
    step(0, 0, 1, 0, 0, 5, 0);
    // R3: writing ones sets nothing
    step(0, 1, 0, 1, 0, 5, 'hFF);
    step(0, 1, 1, 1, 0, 5, 'hFF);
    step(0, 0, 1, 1, 0, 5, 0);
    step(0, 1, 0, 1, 0, 5, 'hF0);
    step(0, 1, 1, 1, 0, 5, 0);
    step(0, 0, 1, 0, 0, 5, 0);
    // R5: inhibit with strobe activity, then enable while strobe low
    step(1, 1, 0, 1, 0, 7, 'h00);
    step(1, 1, 1, 1, 0, 7, 'h00);
    step(1, 1, 0, 1, 0, 7, 'h00);
    step(0, 1, 0, 1, 0, 7, 'h00);
    step(0, 1, 1, 1, 0, 7, 'h00);
    step(0, 0, 1, 0, 0, 7, 0);
    // R12: both oe and strobe low
    step(0, 0, 1, 1, 0, 9, 'h00);
    step(0, 0, 0, 1, 0, 9, 'h00);
    step(0, 0, 1, 1, 0, 9, 'h00);
    step(0, 0, 1, 0, 0, 9, 0);
    // R8 R9 R10: identification bytes, upper lines high
    step(0, 0, 1, 0, 1, 'hC, 0);
    step(0, 0, 1, 0, 1, 'hD, 0);
    step(0, 0, 1, 0, 1, 'hE, 0);
    step(0, 0, 1, 0, 1, 'hF, 0);
    step(0, 0, 1, 0, 1, 'h2, 0);
    step(0, 0, 1, 0, 1, 'h3, 0);
    // R8: identification flag ignored under programming supply
    step(0, 0, 1, 1, 1, 'hE, 0);
    // random mix of all modes
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 9);
      case (r)
        0, 1, 2: step(0, 1, 1'($urandom_range(0, 1)), 1, 0,
                      $urandom_range(0, NB-1), $urandom_range(0, 255));
        3:       step(1, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                      1'($urandom_range(0, 1)), 0, $urandom_range(0, NB-1), 0);
        4:       step(0, 0, 1, 0, 1, $urandom_range(0, NB-1), 0);
        5:       step(0, 0, 1'($urandom_range(0, 1)), 1, 1'($urandom_range(0, 1)),
                      $urandom_range(0, NB-1), $urandom_range(0, 255));
        default: step(0, 1'($urandom_range(0, 1)), 1, 0, 0,
                      $urandom_range(0, NB-1), 0);
      endcase
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule